// File: doc/BRIEF.md
# Interrupt Capture Controller

This block collects a set of device interrupt lines and drives one interrupt request to a processor. Each line passes through a two-flop synchroniser. A per-line detector then turns activity on the line into a sticky pending bit. Each line's sensitivity and active polarity are fixed at build time. A line set to edge sensitivity captures on a transition into its active state. A line set to level sensitivity captures on every cycle in which it sits at its active level. A pending bit stays set until software clears it by writing a one to the acknowledge register. If a clear and a fresh capture fall on the same cycle, the clear takes effect.

Software reaches the block through a small synchronous register port. Writes take effect on the clock edge. Reads return the selected register one cycle after the address is presented. The processor request is raised when the master switch is on and at least one pending line is also unmasked. A vector register names the lowest-numbered pending, unmasked line, which gives software a priority order without scanning.

Top module: `irq_capture_ctrl`

## Requirements
- R1: A pending bit, once set, stays set on every later cycle until a write of 1 to that bit position at the acknowledge register (address 2). Writing 0 to a bit position leaves that bit unchanged.
- R2: `irq_out` is a register. It is high exactly one cycle after a cycle in which the master bit (bit 0 at address 3) was set and some pending bit had its mask bit (address 1) set.
- R3: An edge-sensitive line captures only when its synchronised value changes from inactive to active. Bit i of EDGE_MASK = 1 selects edge sensitivity. Bit i of POL_MASK = 1 makes high (rising) the active state, and 0 makes low (falling) the active state.
- R4: A level-sensitive line (EDGE_MASK bit = 0) captures on every cycle it is at its active level. A level line held active is therefore pending again on the cycle after each acknowledge.
- R5: An edge-sensitive line held active does not capture again after an acknowledge until it has gone inactive and then become active again.
- R6: When an acknowledge and a capture hit the same bit on the same cycle, the bit is clear after that edge.
- R7: Lines capture while their mask bits are clear. The mask affects only `irq_out` and the vector.
- R8: The vector register (address 4) holds the index of the lowest-numbered line that is both pending and unmasked, one cycle after that state arises. When no such line exists, it holds all ones ($clog2(N_LINES)+1 bits, 4'hF for 8 lines).
- R9: Synchronous reset clears all pending bits, the mask and the master bit. It also drives `irq_out` and `reg_rdata` to 0 and sets the vector to all ones.
- R10: A change on a raw input first shows up in the pending bit at the third rising edge after it is applied, because of two synchroniser flops and one capture flop.
- R11: `reg_rdata` shows, one cycle late, the register selected by `reg_addr`: 0 pending, 1 mask, 3 master (bit 0), 4 vector. Address 2 and unused addresses read 0. Writes to addresses 0 and 4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Raw asynchronous device interrupt lines |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | N_LINES | Write data |
| reg_rdata | output | N_LINES | Registered read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to create from the ports is an acknowledge landing on the exact edge where a capture also happens. The raw input reaches the capture stage three edges after it is applied, so a hand-timed pulse rarely lines up with the write. The stimulus gets around this by holding a level-sensitive line at its active level, so that it captures on every cycle. An acknowledge written at any moment then collides with a capture, and the read that follows must show the bit clear before it comes back one cycle later. Random phases mix edges, pulses and acknowledges on all lines against the cycle model to reach further collisions.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    SEL_PENDING = 3'd0,
    SEL_MASK    = 3'd1,
    SEL_CLEAR   = 3'd2,
    SEL_MASTER  = 3'd3,
    SEL_VECTOR  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int N = 8,
  parameter logic [N-1:0] EDGE_MASK = '0,
  parameter logic [N-1:0] POL_MASK  = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] samp,
  input  logic [N-1:0] ack_mask,
  output logic [N-1:0] status
);
  localparam logic [N-1:0] IDLE_LVL = ~POL_MASK;

  logic [N-1:0] prev_q;
  logic [N-1:0] event_w;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic act_now, act_prev;
    assign act_now  = POL_MASK[i] ? samp[i]   : ~samp[i];
    assign act_prev = POL_MASK[i] ? prev_q[i] : ~prev_q[i];
    if (EDGE_MASK[i]) begin : g_edge
      assign event_w[i] = act_now & ~act_prev;
    end else begin : g_level
      assign event_w[i] = act_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= IDLE_LVL;
      status <= '0;
    end else begin
      prev_q <= samp;
      status <= (status | event_w) & ~ack_mask;
    end
  end

  // R1
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(status) & ~$past(ack_mask)) & ~status) == '0));

  // R6
  ack_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(ack_mask)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 8,
  parameter int VW = $clog2(N) + 1
) (
  input  logic [N-1:0]  pend,
  output logic [VW-1:0] vec
);
  always_comb begin
    vec = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) vec = VW'(i);
    end
  end
endmodule

// File: rtl/irq_capture_ctrl.sv
module irq_capture_ctrl
  import irq_pkg::*;
#(
  parameter int N_LINES     = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [N_LINES-1:0] EDGE_MASK = 8'h0F,
  parameter logic [N_LINES-1:0] POL_MASK  = 8'h55
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [2:0]         reg_addr,
  input  logic               reg_wr,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic               irq_out
);
  localparam int VW = $clog2(N_LINES) + 1;
  localparam logic [N_LINES-1:0] IDLE_LVL = ~POL_MASK;

  reg_sel_e sel;
  logic [N_LINES-1:0] samp, status, mask_q, ack_mask, pend_w;
  logic               master_q;
  logic [VW-1:0]      vec_w, vec_q;

  assign sel      = reg_sel_e'(reg_addr);
  assign ack_mask = (reg_wr && sel == SEL_CLEAR) ? reg_wdata : '0;
  assign pend_w   = status & mask_q;

  irq_sync #(.N(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(samp)
  );

  irq_capture #(.N(N_LINES), .EDGE_MASK(EDGE_MASK), .POL_MASK(POL_MASK)) u_cap (
    .clk(clk), .rst(rst), .samp(samp), .ack_mask(ack_mask), .status(status)
  );

  irq_prio_enc #(.N(N_LINES), .VW(VW)) u_enc (
    .pend(pend_w), .vec(vec_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      master_q  <= 1'b0;
      vec_q     <= '1;
      irq_out   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && sel == SEL_MASK)   mask_q   <= reg_wdata;
      if (reg_wr && sel == SEL_MASTER) master_q <= reg_wdata[0];
      vec_q   <= vec_w;
      irq_out <= master_q & (|pend_w);
      case (sel)
        SEL_PENDING: reg_rdata <= status;
        SEL_MASK:    reg_rdata <= mask_q;
        SEL_MASTER:  reg_rdata <= N_LINES'(master_q);
        SEL_VECTOR:  reg_rdata <= N_LINES'(vec_q);
        default:     reg_rdata <= '0;
      endcase
    end
  end

  // R2
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == ($past(master_q) && ($past(status & mask_q) != '0))));

  // R8
  vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_w == '0) |=> (vec_q == '1));

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!irq_out && status == '0 && mask_q == '0 && !master_q));
endmodule

// File: tb/sim_irq_capture_ctrl.sv
module sim_irq_capture_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] EDGE = 8'h0F;
  localparam logic [7:0] POL  = 8'h55;
  localparam logic [7:0] IDLE = ~POL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] irq_in = IDLE;
  logic [2:0] reg_addr = 3'd0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_capture_ctrl #(.N_LINES(8), .SYNC_STAGES(2), .EDGE_MASK(EDGE), .POL_MASK(POL)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R9";
  bit started = 0;
  bit done = 0;

  // behavioural reference
  logic [7:0] m_s1, m_s2, m_prev, m_stat, m_en, m_rd, m_ev, m_ack, m_pe;
  logic       m_master, m_irq;
  logic [3:0] m_vec;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = IDLE; m_s2 = IDLE; m_prev = IDLE;
      m_stat = 0; m_en = 0; m_master = 0; m_irq = 0; m_vec = 4'hF; m_rd = 0;
    end else begin
      m_pe = m_stat & m_en;
      case (reg_addr)
        3'd0: m_rd = m_stat;
        3'd1: m_rd = m_en;
        3'd3: m_rd = {7'd0, m_master};
        3'd4: m_rd = {4'd0, m_vec};
        default: m_rd = 8'd0;
      endcase
      m_irq = m_master && (m_pe != 0);
      m_vec = 4'hF;
      for (int i = 7; i >= 0; i--) if (m_pe[i]) m_vec = 4'(i);
      for (int i = 0; i < 8; i++) begin
        bit a, p;
        a = POL[i] ? m_s2[i] : !m_s2[i];
        p = POL[i] ? m_prev[i] : !m_prev[i];
        m_ev[i] = EDGE[i] ? (a && !p) : a;
      end
      m_ack  = (reg_wr && reg_addr == 3'd2) ? reg_wdata : 8'd0;
      m_stat = (m_stat | m_ev) & ~m_ack;
      if (reg_wr && reg_addr == 3'd1) m_en = reg_wdata;
      if (reg_wr && reg_addr == 3'd3) m_master = reg_wdata[0];
      m_prev = m_s2; m_s2 = m_s1; m_s1 = irq_in;
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if (irq_out !== m_irq) begin
        n_bad++;
        $display("FAIL %s irq_out actual=%0b expected=%0b t=%0t", cur_req, irq_out, m_irq, $time);
      end
      n_cmp++;
      if (reg_rdata !== m_rd) begin
        n_bad++;
        $display("FAIL %s reg_rdata actual=%h expected=%h t=%0t", cur_req, reg_rdata, m_rd, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s directed actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_exp(input string tag, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R9";
    chk("R9", {7'd0, irq_out}, 8'h00);
    rd_exp("R9", 3'd0, 8'h00);
    rd_exp("R9", 3'd4, 8'h0F);
    rd_exp("R9", 3'd1, 8'h00);

    // R10: rising pulse on line 0 appears after three edges
    cur_req = "R10";
    @(negedge clk); reg_addr = 3'd0; irq_in[0] = 1'b1;
    @(negedge clk); irq_in[0] = 1'b0;
    idle(5);
    // R7: captured while masked
    cur_req = "R7";
    rd_exp("R7", 3'd0, 8'h01);
    chk("R7", {7'd0, irq_out}, 8'h00);

    // R2 and R8
    cur_req = "R2";
    wr(3'd1, 8'h01);
    wr(3'd3, 8'h01);
    idle(2);
    chk("R2", {7'd0, irq_out}, 8'h01);
    rd_exp("R8", 3'd4, 8'h00);

    // R1: stays held, unrelated ack leaves it
    cur_req = "R1";
    idle(10);
    wr(3'd2, 8'h02);
    rd_exp("R1", 3'd0, 8'h01);
    wr(3'd2, 8'h01);
    idle(2);
    rd_exp("R1", 3'd0, 8'h00);
    chk("R2", {7'd0, irq_out}, 8'h00);

    // R3 / R5: falling edge on line 1 held low, rising on line 2 held high
    cur_req = "R3";
    @(negedge clk); irq_in[1] = 1'b0; irq_in[2] = 1'b1;
    idle(5);
    rd_exp("R3", 3'd0, 8'h06);
    cur_req = "R5";
    wr(3'd2, 8'h06);
    idle(6);
    rd_exp("R5", 3'd0, 8'h00);
    @(negedge clk); irq_in[1] = 1'b1; irq_in[2] = 1'b0;
    idle(4);
    @(negedge clk); irq_in[1] = 1'b0;
    idle(5);
    rd_exp("R5", 3'd0, 8'h02);
    wr(3'd2, 8'h02);

    // R4 and R6: level line 4 held high, low-active line 5 held low
    cur_req = "R4";
    @(negedge clk); irq_in[4] = 1'b1; irq_in[5] = 1'b0;
    idle(5);
    rd_exp("R4", 3'd0, 8'h30);
    cur_req = "R6";
    @(negedge clk); reg_addr = 3'd2; reg_wr = 1'b1; reg_wdata = 8'h10;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 3'd0;
    @(negedge clk); chk("R6", reg_rdata, 8'h20);
    @(negedge clk); chk("R4", reg_rdata, 8'h30);
    @(negedge clk); irq_in[4] = 1'b0; irq_in[5] = 1'b1;
    idle(4);
    wr(3'd2, 8'h30);

    // R8 priority among several
    cur_req = "R8";
    wr(3'd1, 8'hFF);
    @(negedge clk); irq_in[6] = 1'b1; irq_in[7] = 1'b0; irq_in[3] = 1'b0;
    idle(5);
    rd_exp("R8", 3'd4, 8'h03);
    wr(3'd2, 8'h08);
    idle(2);
    rd_exp("R8", 3'd4, 8'h06);
    @(negedge clk); irq_in[6] = 1'b0; irq_in[7] = 1'b1;
    idle(4);
    wr(3'd2, 8'hFF);
    idle(2);
    rd_exp("R8", 3'd4, 8'h0F);

    // R11: read-only writes ignored, ack reads zero
    cur_req = "R11";
    wr(3'd0, 8'hFF);
    wr(3'd4, 8'h00);
    rd_exp("R11", 3'd0, 8'h00);
    rd_exp("R11", 3'd4, 8'h0F);
    rd_exp("R11", 3'd2, 8'h00);
    rd_exp("R11", 3'd3, 8'h01);
    rd_exp("R11", 3'd1, 8'hFF);

    // random mix against the model
    cur_req = "R3";
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      irq_in    = 8'($urandom);
      reg_addr  = 3'($urandom_range(0, 5));
      reg_wr    = ($urandom_range(0, 3) == 0);
      reg_wdata = 8'($urandom);
    end
    @(negedge clk); reg_wr = 1'b0;

    // R9: reset mid-run
    cur_req = "R9";
    rst = 1'b1;
    idle(2);
    rst = 1'b0; irq_in = IDLE;
    rd_exp("R9", 3'd3, 8'h00);
    rd_exp("R9", 3'd0, 8'h00);
    idle(3);
    finish_run();
  end
endmodule